// File: doc/BRIEF.md
# Line-Granular Load-Locked Reservation Monitor

This block tracks atomic-sequence reservations for a small shared-memory multiprocessor whose cores use load-locked and store-conditional pairs. Each core may hold one reservation. A reservation names a 64-byte line: the physical address of the load-locked with its six low bits forced to zero. Requests arrive one per cycle, each carrying the issuing core's index, an operation code and a physical address. The 32-bit and 64-bit forms of an operation share one code, because the reservation is kept per line and not per word.

For a store-conditional, the block decides in the same cycle whether the write may reach memory, and it produces the 0/1 value that goes to the destination register. Every completed store cancels reservations on the line it touches, whichever core issues it. A failed store-conditional counts as a completed store here. Any store or store-conditional also drops the issuing core's own reservation. A running count of live reservations is kept. A debug port shows the reserved line of any chosen core. Memory, translation and uncached paths live outside the block.

Top module: `resv_monitor`

## Requirements
- R1: After reset the live count is 0 and the debug port reads 0 for every core.
- R2: A reservation records the request address with bits [5:0] cleared, and the debug port shows that aligned address. A store-conditional to any byte of the same 64-byte line matches it.
- R3: A load-locked (op code 1) from a core that holds no reservation sets that core's reservation. The live count rises by one on the next cycle.
- R4: A load-locked from a core that already holds a reservation replaces the recorded line and leaves the live count unchanged.
- R5: During a valid store-conditional (op code 3), `scAllow` is 1 and `scStatus` equals 1 exactly when the issuer holds a reservation on the addressed line. Otherwise both are 0. Both are 0 whenever no store-conditional is presented.
- R6: After a plain store (op code 2) or a store-conditional, successful or not, every other core whose reservation names the addressed line loses it. Cores reserving other lines keep theirs. The live count falls by the number of reservations dropped.
- R7: After a plain store or store-conditional, the issuer's own reservation is dropped whatever line it names.
- R8: A plain load (op code 0), or any request with `reqValid` low, changes no reservation and no count.
- R9: The live count always equals the number of cores holding a reservation and never drops below zero.
- R10: `dbgLine` returns the reserved aligned address of core `dbgCpu` combinationally, or 0 if that core holds no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqCpu | input | CPU_W (2) | Index of the issuing core |
| reqOp | input | 2 | 0 load, 1 load-locked, 2 store, 3 store-conditional |
| reqAddr | input | ADDR_W (32) | Physical byte address |
| dbgCpu | input | CPU_W (2) | Core whose reservation is shown on dbgLine |
| scAllow | output | 1 | Store-conditional may write memory |
| scStatus | output | RESULT_W (64) | Value for the destination register (0 or 1) |
| liveCount | output | CNT_W (3) | Number of live reservations |
| dbgLine | output | ADDR_W (32) | Reserved aligned address of dbgCpu, or 0 |

## Verification
The assertions assume that requests are already serialized, with at most one request per cycle, and that `reqCpu` always names an existing core. The bench presents one request per clock and draws core indices only from 0 to NUM_CPU-1. The bench also concentrates addresses on three neighbouring lines and varies the byte offset inside each line, so that peer cancellation, line replacement and mismatched store-conditionals occur often. A model in the bench computes the expected reservation state arithmetically and compares it with every core's debug readout.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_LOCK  = 2'd1,
    OP_STORE = 2'd2,
    OP_COND  = 2'd3
  } reqOp_e;

  typedef struct packed {
    logic arm;    // take or replace a reservation
    logic sweep;  // completed store: cancel touched reservations
    logic probe;  // store-conditional: evaluate permission
  } strobe_t;
endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int RESULT_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic                ownHit,
  output strobe_t             strobe,
  output logic                scAllow,
  output logic [RESULT_W-1:0] scStatus
);
  always_comb begin
    strobe = '0;
    if (reqValid) begin
      case (reqOp)
        OP_LOCK:  strobe.arm = 1'b1;
        OP_STORE: strobe.sweep = 1'b1;
        OP_COND: begin
          strobe.sweep = 1'b1;
          strobe.probe = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign scAllow  = strobe.probe && ownHit;
  assign scStatus = {{(RESULT_W-1){1'b0}}, scAllow};

  // R5
  cond_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    scAllow |-> (reqValid && reqOp == OP_COND));
endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W     = $clog2(NUM_CPU + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CPU_W-1:0]  dbgCpu,
  output logic              ownHit,
  output logic [CNT_W-1:0]  liveCount,
  output logic [ADDR_W-1:0] dbgLine
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));

  logic [ADDR_W-1:0] aligned;
  logic [NUM_CPU-1:0] flags;
  logic [ADDR_W-1:0] lines [NUM_CPU];
  logic [NUM_CPU-1:0] lineEq, isSelf, drop, armSel;
  logic anyLive, growth;
  logic [CNT_W-1:0] dropCnt, setCnt, countNext;

  assign aligned = reqAddr & LINE_MASK;
  assign anyLive = (liveCount != '0);

  for (genvar g = 0; g < NUM_CPU; g++) begin : gSlot
    assign lineEq[g] = (lines[g] == aligned);
    assign isSelf[g] = (reqCpu == CPU_W'(g));
    assign armSel[g] = strobe.arm && isSelf[g];
    assign drop[g]   = strobe.sweep && anyLive && flags[g] && (isSelf[g] || lineEq[g]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[g] <= 1'b0;
        lines[g] <= '0;
      end else if (armSel[g]) begin
        flags[g] <= 1'b1;
        lines[g] <= aligned;
      end else if (drop[g]) begin
        flags[g] <= 1'b0;
        lines[g] <= '0;
      end
    end
  end

  assign ownHit = flags[reqCpu] && lineEq[reqCpu];
  assign growth = strobe.arm && !flags[reqCpu];

  always_comb begin
    dropCnt = '0;
    setCnt  = '0;
    for (int k = 0; k < NUM_CPU; k++) begin
      dropCnt = dropCnt + CNT_W'(drop[k]);
      setCnt  = setCnt + CNT_W'(flags[k]);
    end
  end

  assign countNext = liveCount + CNT_W'(growth) - dropCnt;

  always_ff @(posedge clk) begin
    if (!rstN) liveCount <= '0;
    else       liveCount <= countNext;
  end

  assign dbgLine = flags[dbgCpu] ? lines[dbgCpu] : '0;

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropCnt <= liveCount);
  // R9
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    liveCount == setCnt);
  // R3
  lock_record_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arm |=> (flags[$past(reqCpu)] && lines[$past(reqCpu)] == $past(aligned)));
  // R4
  relock_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arm && flags[reqCpu]) |=> (liveCount == $past(liveCount)));
  // R7
  own_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sweep |=> !flags[$past(reqCpu)]);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int RESULT_W   = 64,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W     = $clog2(NUM_CPU + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [CPU_W-1:0]    reqCpu,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [CPU_W-1:0]    dbgCpu,
  output logic                scAllow,
  output logic [RESULT_W-1:0] scStatus,
  output logic [CNT_W-1:0]    liveCount,
  output logic [ADDR_W-1:0]   dbgLine
);
  strobe_t strobe;
  logic ownHit;

  resv_ctrl #(.RESULT_W(RESULT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .ownHit(ownHit), .strobe(strobe), .scAllow(scAllow), .scStatus(scStatus)
  );

  resv_datapath #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCpu(reqCpu), .reqAddr(reqAddr),
    .dbgCpu(dbgCpu), .ownHit(ownHit), .liveCount(liveCount), .dbgLine(dbgLine)
  );
endmodule

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
  localparam int PERIOD = 10;
  localparam int NCPU = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqCpu = '0;
  logic [1:0] reqOp = '0;
  logic [31:0] reqAddr = '0;
  logic [1:0] dbgCpu = '0;
  logic scAllow;
  logic [63:0] scStatus;
  logic [2:0] liveCount;
  logic [31:0] dbgLine;

  int checks = 0;
  int fails = 0;
  logic mFlag [NCPU];
  logic [31:0] mLine [NCPU];
  int mCnt = 0;

  always #(PERIOD/2) clk = ~clk;

  resv_monitor uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCpu(reqCpu), .reqOp(reqOp),
    .reqAddr(reqAddr), .dbgCpu(dbgCpu), .scAllow(scAllow), .scStatus(scStatus),
    .liveCount(liveCount), .dbgLine(dbgLine)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(string req);
    @(negedge clk);
    reqValid = 1'b0;
    #1 chk(req, "liveCount", 64'(liveCount), 64'(mCnt));
    for (int k = 0; k < NCPU; k++) begin
      dbgCpu = 2'(k);
      #1 chk(req, "dbgLine", 64'(dbgLine), 64'(mFlag[k] ? mLine[k] : 32'h0));
    end
  endtask

  task automatic issue(string req, int cpu, int op, logic [31:0] addr);
    logic [31:0] al;
    logic hit;
    @(negedge clk);
    reqValid = 1'b1;
    reqCpu = 2'(cpu);
    reqOp = 2'(op);
    reqAddr = addr;
    al = addr & 32'hffff_ffc0;
    hit = (op == 3) && mFlag[cpu] && (mLine[cpu] == al);
    #2;
    chk(req, "scAllow", 64'(scAllow), 64'(hit));
    chk(req, "scStatus", scStatus, 64'(hit));
    if (op == 1) begin
      if (!mFlag[cpu]) mCnt++;
      mFlag[cpu] = 1'b1;
      mLine[cpu] = al;
    end else if (op >= 2) begin
      for (int k = 0; k < NCPU; k++)
        if (mFlag[k] && (k == cpu || mLine[k] == al)) begin
          mFlag[k] = 1'b0;
          mCnt--;
        end
    end
    @(posedge clk);
  endtask

  task automatic idleReq(string req, int cpu, int op, logic [31:0] addr);
    @(negedge clk);
    reqValid = 1'b0;
    reqCpu = 2'(cpu);
    reqOp = 2'(op);
    reqAddr = addr;
    #2 chk(req, "scAllow idle", 64'(scAllow), 64'd0);
    @(posedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int k = 0; k < NCPU; k++) begin mFlag[k] = 1'b0; mLine[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    checkState("R1");

    // R2 R3: aligned record and count growth
    issue("R3", 0, 1, 32'h1000_0044);
    checkState("R2");
    // R2 R5: other offset in the same line succeeds; R7 own reservation cleared
    issue("R5", 0, 3, 32'h1000_007c);
    checkState("R7");
    // R5: no reservation -> failure
    issue("R5", 1, 3, 32'h1000_0040);
    checkState("R5");
    // R4: relock replaces line, count unchanged; old line no longer matches
    issue("R4", 1, 1, 32'h0000_0200);
    issue("R4", 1, 1, 32'h0000_0300);
    checkState("R4");
    issue("R4", 1, 3, 32'h0000_0208);
    checkState("R4");
    // R6: peers on the touched line drop, others stay
    issue("R6", 0, 1, 32'h0000_0400);
    issue("R6", 2, 1, 32'h0000_0420);
    issue("R6", 3, 1, 32'h0000_0480);
    checkState("R6");
    issue("R6", 1, 2, 32'h0000_0410);
    checkState("R6");
    // R7: plain store to a foreign line still drops own reservation
    issue("R7", 3, 2, 32'h0000_0900);
    checkState("R7");
    // R6: failed store-conditional still cancels peers
    issue("R6", 0, 1, 32'h0000_0700);
    issue("R6", 1, 3, 32'h0000_0704);
    checkState("R6");
    // R8: loads and invalid requests have no effect
    issue("R8", 2, 1, 32'h0000_0600);
    issue("R8", 2, 0, 32'h0000_0600);
    issue("R8", 0, 0, 32'h0000_0610);
    idleReq("R8", 2, 3, 32'h0000_0600);
    idleReq("R8", 1, 2, 32'h0000_0600);
    checkState("R8");
    // R5 success for a peer still holding after the R8 stimulus
    issue("R5", 2, 3, 32'h0000_063f);
    checkState("R9");

    // R9 R10: pseudo-random sweep over three adjacent lines
    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      int lineSel;
      seed = seed * 32'd1103515245 + 32'd12345;
      lineSel = int'(seed[27:24]) % 3;
      issue("R9", int'(seed[17:16]), int'(seed[21:20]),
            32'h0000_2000 + 32'(lineSel * 64) + 32'(seed[5:0]));
      if (i % 8 == 7) checkState("R10");
    end
    checkState("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule